// File: doc/BRIEF.md
# Flash OTP Program Command Sequencer

This block sits on the host side of an asynchronous parallel NOR flash. It programs one-time-programmable locations for a requester. A request carries a target address, a data byte and a flag that marks the last program of a batch. For each request the sequencer writes the OTP setup command and then the data byte. It then writes the read-status command and polls the status register until the device's internal write engine reports ready.

Error flags in the flash status register are sticky, so checking them may wait until the end of a batch. For a program that is not the last, the sequencer reports only completion. For the last program it decodes the voltage, protection and program-failure flags in priority order. If no flag is set, it puts the device back in read-array mode. When it reports an error, or when polling times out, the sequencer locks and ignores new requests. It leaves that state only after the requester asks for a clear. The clear writes the clear-status command and then returns the device to read-array mode.

Each bus access holds chip-enable low for a fixed number of clock cycles, with either write-enable or output-enable low. It is followed by one idle recovery cycle.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high, and `busy`, `done` and `err` are all zero.
- R2: An accepted request produces bus writes in this order: C0h at the target address, the data byte at the target address, then 70h. Status reads follow.
- R3: Every access keeps `fl_ce_n` low for exactly ACC_CYC cycles. During that time exactly one of `fl_we_n` and `fl_oe_n` is low, and `fl_dq_oe` is high only while `fl_we_n` is low.
- R4: Status reads repeat while bit 7 of the read value is 0. The first read with bit 7 equal to 1 ends polling, so K busy reads give K+1 reads in total.
- R5: A request with `req_batch_last`=0 ends with a `done` pulse and `err`=0, whatever the status bits 4, 3 and 1 hold.
- R6: A request with `req_batch_last`=1 reports a one-hot `err` with `done`. The encoding is err[2] for status bit 3 (voltage range), err[1] for status bit 1 (protected) and err[0] for status bit 4 (program failure). Priority is bit 3 over bit 1 over bit 4.
- R7: A last request with no error flag writes FFh after polling, then pulses `done` with `err`=0.
- R8: After a `done` with nonzero `err`, the block stays locked and makes no bus access until `req_clear`. A `req_start` pulse in that state has no effect.
- R9: A `req_clear` in the locked state writes 50h and then FFh, then pulses `done` with `err`=0. After that the block accepts requests again.
- R10: If POLL_MAX status reads in a row return bit 7 = 0, the block pulses `done` with `err`=4'b1000 (err[3], timeout only) and locks.
- R11: `busy` is high from the cycle after a request is accepted until the result. `done` is a single-cycle pulse with `busy` low. A `req_start` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Request pulse, taken when idle |
| req_addr | input | AW | Target OTP address |
| req_data | input | 8 | Byte to program |
| req_batch_last | input | 1 | Last program of a batch: run full status check |
| req_clear | input | 1 | Clear status and unlock after an error |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle result pulse |
| err | output | 4 | {timeout, voltage, protect, program}, valid with done |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | AW | Flash address |
| fl_dq_out | output | 8 | Data driven to flash |
| fl_dq_oe | output | 1 | Drive enable for fl_dq_out |
| fl_dq_in | input | 8 | Data read from flash |

## Verification
The bench drives a behavioural flash that holds sticky status flags and is ready after a chosen number of busy reads. It tries single programs with different ready delays, which separates a sequencer that stops polling early from one that polls too long. It runs batches where a non-last program injects an error that only the last program reports, which tells deferred checking apart from per-program checking. It also injects flag combinations that separate the three priority ranks from each other. A device that never becomes ready, start pulses while busy or locked, and a constrained random mix of addresses, data, batch flags and errors complete the set. Expected results come from a bench model of sticky status and priority.

// File: rtl/otp_seq_pkg.sv
package otp_seq_pkg;

    localparam logic [7:0] CMD_OTP_SETUP  = 8'hC0;
    localparam logic [7:0] CMD_READ_STAT  = 8'h70;
    localparam logic [7:0] CMD_CLR_STAT   = 8'h50;
    localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;

    localparam int SB_READY = 7;
    localparam int SB_PROG  = 4;
    localparam int SB_VOLT  = 3;
    localparam int SB_LOCK  = 1;

    typedef enum logic [3:0] {
        S_IDLE, S_SETUP, S_DATA, S_RSR, S_POLL,
        S_ARRAY, S_CLR, S_CLR_FF, S_HOLD
    } seq_state_e;

    typedef struct packed {
        logic timeout;
        logic volt;
        logic lock;
        logic prog;
    } err_vec_t;

    // Priority decode of sticky flags: voltage, then protection, then program failure
    function automatic err_vec_t decode_status(input logic [7:0] s);
        err_vec_t e;
        e = '0;
        if (s[SB_VOLT])      e.volt = 1'b1;
        else if (s[SB_LOCK]) e.lock = 1'b1;
        else if (s[SB_PROG]) e.prog = 1'b1;
        return e;
    endfunction

endpackage

// File: rtl/otp_bus_port.sv
module otp_bus_port #(
    parameter int AW      = 20,
    parameter int ACC_CYC = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic          ack,
    output logic [7:0]    rdata,
    output logic          ce_n,
    output logic          we_n,
    output logic          oe_n,
    output logic [AW-1:0] addr_o,
    output logic [7:0]    dq_out,
    output logic          dq_oe,
    input  logic [7:0]    dq_in
);
    localparam int CW = (ACC_CYC > 1) ? $clog2(ACC_CYC) : 1;

    typedef enum logic [1:0] {B_IDLE, B_ACT, B_REC} bus_ph_e;

    bus_ph_e        ph;
    logic [CW-1:0]  cnt;
    logic           wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph     <= B_IDLE;
            cnt    <= '0;
            wr_q   <= 1'b0;
            addr_o <= '0;
            dq_out <= '0;
            rdata  <= '0;
        end else begin
            case (ph)
                B_IDLE: if (go) begin
                    ph     <= B_ACT;
                    cnt    <= '0;
                    wr_q   <= wr;
                    addr_o <= addr;
                    dq_out <= wdata;
                end
                B_ACT: begin
                    if (cnt == CW'(ACC_CYC - 1)) begin
                        ph <= B_REC;
                        if (!wr_q) rdata <= dq_in;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ph <= B_IDLE;
            endcase
        end
    end

    assign ce_n  = (ph != B_ACT);
    assign we_n  = !((ph == B_ACT) && wr_q);
    assign oe_n  = !((ph == B_ACT) && !wr_q);
    assign dq_oe = (ph == B_ACT) && wr_q;
    assign ack   = (ph == B_REC);

endmodule

// File: rtl/otp_poll_ctr.sv
module otp_poll_ctr #(
    parameter int POLL_MAX = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic last
);
    localparam int PW = (POLL_MAX > 1) ? $clog2(POLL_MAX) : 1;

    logic [PW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) cnt <= '0;
        else if (inc && !last) cnt <= cnt + 1'b1;
    end

    assign last = (cnt == PW'(POLL_MAX - 1));

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
    import otp_seq_pkg::*;
#(
    parameter int AW       = 20,
    parameter int ACC_CYC  = 3,
    parameter int POLL_MAX = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_start,
    input  logic [AW-1:0] req_addr,
    input  logic [7:0]    req_data,
    input  logic          req_batch_last,
    input  logic          req_clear,
    output logic          busy,
    output logic          done,
    output logic [3:0]    err,
    output logic          fl_ce_n,
    output logic          fl_we_n,
    output logic          fl_oe_n,
    output logic [AW-1:0] fl_addr,
    output logic [7:0]    fl_dq_out,
    output logic          fl_dq_oe,
    input  logic [7:0]    fl_dq_in
);
    seq_state_e    st;
    logic [AW-1:0] addr_q;
    logic [7:0]    data_q;
    logic          last_q;
    logic          pend;
    err_vec_t      err_q;
    logic          done_q;

    logic          acc_go, acc_wr, acc_ack, poll_last;
    logic [7:0]    acc_wdata, acc_rdata;
    err_vec_t      stat_err;

    assign busy   = !((st == S_IDLE) || (st == S_HOLD));
    assign acc_go = busy && !pend;
    assign acc_wr = (st != S_POLL);

    always_comb begin
        case (st)
            S_SETUP:           acc_wdata = CMD_OTP_SETUP;
            S_DATA:            acc_wdata = data_q;
            S_RSR:             acc_wdata = CMD_READ_STAT;
            S_CLR:             acc_wdata = CMD_CLR_STAT;
            S_ARRAY, S_CLR_FF: acc_wdata = CMD_READ_ARRAY;
            default:           acc_wdata = 8'h00;
        endcase
    end

    assign stat_err = decode_status(acc_rdata);

    otp_bus_port #(.AW(AW), .ACC_CYC(ACC_CYC)) u_bus (
        .clk(clk), .rst(rst),
        .go(acc_go), .wr(acc_wr), .addr(addr_q), .wdata(acc_wdata),
        .ack(acc_ack), .rdata(acc_rdata),
        .ce_n(fl_ce_n), .we_n(fl_we_n), .oe_n(fl_oe_n),
        .addr_o(fl_addr), .dq_out(fl_dq_out), .dq_oe(fl_dq_oe),
        .dq_in(fl_dq_in)
    );

    otp_poll_ctr #(.POLL_MAX(POLL_MAX)) u_poll (
        .clk(clk), .rst(rst),
        .clr(st == S_RSR),
        .inc((st == S_POLL) && acc_ack && !acc_rdata[SB_READY]),
        .last(poll_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            addr_q <= '0;
            data_q <= '0;
            last_q <= 1'b0;
            pend   <= 1'b0;
            err_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (acc_go)       pend <= 1'b1;
            else if (acc_ack) pend <= 1'b0;
            case (st)
                S_IDLE: if (req_start) begin
                    addr_q <= req_addr;
                    data_q <= req_data;
                    last_q <= req_batch_last;
                    st     <= S_SETUP;
                end
                S_SETUP: if (acc_ack) st <= S_DATA;
                S_DATA:  if (acc_ack) st <= S_RSR;
                S_RSR:   if (acc_ack) st <= S_POLL;
                S_POLL: if (acc_ack) begin
                    if (acc_rdata[SB_READY]) begin
                        if (!last_q) begin
                            done_q <= 1'b1;
                            err_q  <= '0;
                            st     <= S_IDLE;
                        end else if (stat_err != '0) begin
                            done_q <= 1'b1;
                            err_q  <= stat_err;
                            st     <= S_HOLD;
                        end else begin
                            st <= S_ARRAY;
                        end
                    end else if (poll_last) begin
                        done_q        <= 1'b1;
                        err_q         <= '0;
                        err_q.timeout <= 1'b1;
                        st            <= S_HOLD;
                    end
                end
                S_HOLD:  if (req_clear) st <= S_CLR;
                S_CLR:   if (acc_ack) st <= S_CLR_FF;
                S_ARRAY, S_CLR_FF: if (acc_ack) begin
                    done_q <= 1'b1;
                    err_q  <= '0;
                    st     <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    assign done = done_q;
    assign err  = err_q;

endmodule

// File: rtl/otp_prog_seq_chk.sv
module otp_prog_seq_chk
    import otp_seq_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       busy,
    input logic       done,
    input logic [3:0] err,
    input logic       fl_ce_n,
    input logic       fl_we_n,
    input logic       fl_oe_n,
    input logic       fl_dq_oe,
    input logic       req_start,
    input logic       req_clear,
    input seq_state_e st
);
    a_r3_write_strobe: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> (!fl_ce_n && fl_oe_n && fl_dq_oe));

    a_r3_read_strobe: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> (!fl_ce_n && fl_we_n && !fl_dq_oe));

    a_r6_err_onehot: assert property (@(posedge clk) disable iff (rst)
        done |-> $onehot0(err));

    a_r11_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r11_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r8_hold_quiet: assert property (@(posedge clk) disable iff (rst)
        (st == S_HOLD) |-> fl_ce_n);

    a_r8_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (st == S_HOLD && req_start && !req_clear) |=> (st == S_HOLD));

endmodule

bind otp_prog_seq otp_prog_seq_chk u_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .err(err),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .fl_dq_oe(fl_dq_oe), .req_start(req_start), .req_clear(req_clear),
    .st(st)
);

// File: tb/sim_otp_prog_seq.sv
`timescale 1ns/1ps
module sim_otp_prog_seq;
    localparam int AW = 20;
    localparam int ACC = 3;
    localparam int PMAX = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_start = 1'b0, req_batch_last = 1'b0, req_clear = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic busy, done, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
    logic [3:0] err;
    logic [AW-1:0] fl_addr;
    logic [7:0] fl_dq_out, fl_dq_in;

    always #4 clk = ~clk;

    otp_prog_seq #(.AW(AW), .ACC_CYC(ACC), .POLL_MAX(PMAX)) u0 (.*);

    int n_chk = 0, n_bad = 0;

    // ---------------- behavioural flash ----------------
    logic        m_stat_mode = 1'b0, m_next_data = 1'b0;
    logic [7:0]  m_flags = '0;          // bits 4,3,1 sticky
    int          m_busy_left = 0;
    logic [7:0]  inj_bits = '0;
    int          rdy_after = 0;
    logic [AW-1:0] wlog_a [0:1023];
    logic [7:0]  wlog_d [0:1023];
    int          wcnt = 0, rcnt = 0;
    logic [AW-1:0] prog_a = '0;
    logic [7:0]  prog_d = '0;

    assign fl_dq_in = m_stat_mode ? {(m_busy_left == 0), 2'b00, m_flags[4], m_flags[3], 1'b0, m_flags[1], 1'b0}
                                  : 8'hA5;

    always @(posedge fl_we_n) begin
        if (!rst) begin
            if (wcnt < 1024) begin
                wlog_a[wcnt] = fl_addr;
                wlog_d[wcnt] = fl_dq_out;
            end
            wcnt++;
            if (m_next_data) begin
                m_next_data = 1'b0;
                prog_a = fl_addr;
                prog_d = fl_dq_out;
                m_flags = m_flags | (inj_bits & 8'h1A);
                m_busy_left = rdy_after;
                m_stat_mode = 1'b1;
            end else begin
                case (fl_dq_out)
                    8'hC0: begin m_next_data = 1'b1; m_stat_mode = 1'b1; end
                    8'h70: m_stat_mode = 1'b1;
                    8'h50: m_flags = '0;
                    8'hFF: m_stat_mode = 1'b0;
                    default: ;
                endcase
            end
        end
    end

    always @(posedge fl_oe_n) begin
        if (!rst) begin
            rcnt++;
            if (m_stat_mode && m_busy_left > 0) m_busy_left--;
        end
    end

    // ce_n low-run length monitor (R3)
    int run = 0, run_min = 1000, run_max = 0;
    always @(negedge clk) begin
        if (!fl_ce_n) run++;
        else if (run > 0) begin
            if (run < run_min) run_min = run;
            if (run > run_max) run_max = run;
            run = 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_err(input logic [7:0] sticky, input bit last, input bit tmo);
        if (tmo) return 4'b1000;
        if (!last) return 4'b0000;
        if (sticky[3]) return 4'b0100;
        if (sticky[1]) return 4'b0010;
        if (sticky[4]) return 4'b0001;
        return 4'b0000;
    endfunction

    task automatic wait_done(output logic [3:0] got);
        int k;
        k = 0;
        while (!done && k < 3000) begin @(negedge clk); k++; end
        got = err;
        @(negedge clk);
    endtask

    task automatic do_prog(input logic [AW-1:0] a, input logic [7:0] d, input bit last,
                           input logic [7:0] inj, input int rdy, output logic [3:0] got);
        inj_bits = inj;
        rdy_after = rdy;
        @(negedge clk);
        req_addr = a; req_data = d; req_batch_last = last; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        wait_done(got);
    endtask

    task automatic do_clear(output logic [3:0] got);
        @(negedge clk);
        req_clear = 1'b1;
        @(negedge clk);
        req_clear = 1'b0;
        wait_done(got);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [3:0] got;
        logic [7:0] sticky;
        int w0, r0;
        void'($urandom(32'h5EED));
        sticky = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(fl_ce_n && fl_we_n && fl_oe_n, "R1", "strobes", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
        chk(!busy && !done && err == 0, "R1", "busy/done/err", {busy, done, err}, 0);

        // R2/R4/R7/R11 directed single last program, busy and mid-op start
        w0 = wcnt; r0 = rcnt;
        inj_bits = 0; rdy_after = 2;
        @(negedge clk);
        req_addr = 20'h12345; req_data = 8'h3C; req_batch_last = 1'b1; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        chk(busy == 1'b1, "R11", "busy after accept", busy, 1);
        repeat (5) @(negedge clk);
        req_addr = 20'h0BEEF; req_data = 8'h11; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        wait_done(got);
        chk(got == 0, "R7", "err clean last", got, 0);
        chk(wcnt - w0 == 4, "R7", "write count", wcnt - w0, 4);
        chk(wlog_d[w0] == 8'hC0 && wlog_a[w0] == 20'h12345, "R2", "setup write", wlog_d[w0], 8'hC0);
        chk(wlog_d[w0+1] == 8'h3C && wlog_a[w0+1] == 20'h12345, "R2", "data write", wlog_d[w0+1], 8'h3C);
        chk(wlog_d[w0+2] == 8'h70, "R2", "read-status cmd", wlog_d[w0+2], 8'h70);
        chk(wlog_d[w0+3] == 8'hFF, "R7", "read-array cmd", wlog_d[w0+3], 8'hFF);
        chk(rcnt - r0 == 3, "R4", "poll reads", rcnt - r0, 3);
        chk(prog_a == 20'h12345, "R11", "start while busy ignored", prog_a, 20'h12345);
        chk(!busy, "R11", "idle after done", busy, 0);

        // R4 longer poll
        r0 = rcnt;
        do_prog(20'h00001, 8'h5A, 1'b0, 8'h00, 7, got);
        chk(rcnt - r0 == 8, "R4", "poll reads 7 busy", rcnt - r0, 8);

        // R5 deferred, then R6 at batch end, R8 lock, R9 clear
        do_prog(20'h00010, 8'h01, 1'b0, 8'h02, 1, got);
        chk(got == 0, "R5", "deferred protect not reported", got, 0);
        do_prog(20'h00011, 8'h02, 1'b1, 8'h00, 1, got);
        chk(got == 4'b0010, "R6", "protect at batch end", got, 4'b0010);
        chk(wlog_d[wcnt-1] == 8'h70, "R8", "no read-array on error", wlog_d[wcnt-1], 8'h70);
        w0 = wcnt;
        @(negedge clk); req_start = 1'b1; @(negedge clk); req_start = 1'b0;
        repeat (40) @(negedge clk);
        chk(wcnt == w0 && !done && !busy, "R8", "start ignored while locked", wcnt - w0, 0);
        w0 = wcnt;
        do_clear(got);
        chk(got == 0, "R9", "clear result", got, 0);
        chk(wcnt - w0 == 2 && wlog_d[w0] == 8'h50 && wlog_d[w0+1] == 8'hFF, "R9", "clear writes", wlog_d[w0], 8'h50);
        chk(m_flags == 0, "R9", "flags cleared", m_flags, 0);
        do_prog(20'h00020, 8'h77, 1'b1, 8'h00, 0, got);
        chk(got == 0 && prog_a == 20'h00020, "R9", "accepts after clear", prog_a, 20'h00020);

        // R6 priority
        do_prog(20'h00030, 8'h10, 1'b1, 8'h18, 0, got);
        chk(got == 4'b0100, "R6", "volt over program", got, 4'b0100);
        do_clear(got);
        do_prog(20'h00031, 8'h11, 1'b1, 8'h12, 0, got);
        chk(got == 4'b0010, "R6", "protect over program", got, 4'b0010);
        do_clear(got);
        do_prog(20'h00032, 8'h12, 1'b1, 8'h0A, 0, got);
        chk(got == 4'b0100, "R6", "volt over protect", got, 4'b0100);
        do_clear(got);
        do_prog(20'h00033, 8'h13, 1'b1, 8'h10, 0, got);
        chk(got == 4'b0001, "R6", "program only", got, 4'b0001);
        do_clear(got);

        // R10 timeout
        r0 = rcnt;
        do_prog(20'h00040, 8'h40, 1'b0, 8'h00, 1000, got);
        chk(got == 4'b1000, "R10", "timeout err", got, 4'b1000);
        chk(rcnt - r0 == PMAX, "R10", "reads before timeout", rcnt - r0, PMAX);
        do_clear(got);
        chk(got == 0, "R10", "clear after timeout", got, 0);

        // random mix
        for (int i = 0; i < 30; i++) begin
            logic [AW-1:0] a;
            logic [7:0] d, inj;
            bit last;
            int rdy, pick;
            logic [3:0] e;
            a = AW'($urandom);
            d = 8'($urandom);
            last = ($urandom % 3) == 0;
            pick = $urandom % 8;
            inj = (pick == 0) ? 8'h08 : (pick == 1) ? 8'h02 : (pick == 2) ? 8'h10 : 8'h00;
            rdy = $urandom % 4;
            sticky = sticky | inj;
            e = exp_err(sticky, last, 1'b0);
            do_prog(a, d, last, inj, rdy, got);
            chk(got == e, last ? "R6" : "R5", "random err", got, e);
            chk(prog_a == a && prog_d == d, "R2", "random programmed location", prog_d, d);
            if (got != 0) begin
                do_clear(got);
                sticky = '0;
            end
        end

        chk(run_min == ACC && run_max == ACC, "R3", "ce low length", run_max, ACC);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule